// File: doc/BRIEF.md
# Interleaved memory bank scheduler

This block sits in front of a word-addressed memory that is split into interleaved banks. Two requesters, an I/O section and a CPU, each present single-word reads and writes on their own valid/ready channel. The block merges them onto one internal port. It picks the bank from the low address bits and keeps a recovery counter for every bank. A request whose bank is still recovering waits at its port with ready low. Requests that go to idle banks are taken at one word per clock.

Each bank holds its words in a local array of 72-bit entries, which is 64 data bits and 8 check bits stored unchanged. A read produces one response a fixed number of clocks after it is accepted. The response carries the requester's tag and a source flag, and responses leave in the order their reads were accepted. A static mode input selects between the full bank count and half of it. The half count serves a smaller memory configuration.

Top module: `bank_sched`

## Requirements
- R1: While reset is low and in the first cycle after it is released, rsp_valid is 0. With no requests and all banks idle after reset, io_ready and cpu_ready are both 1.
- R2: With eight_bank = 0 the bank is address bits [3:0] and the row is the bits above them. With eight_bank = 1 the bank is bits [2:0] and the row is the bits above bit 2.
- R3: After a request to a bank is accepted in cycle t, no further request to that bank is accepted in cycles t+1 to t+3. A waiting request to that bank is accepted in cycle t+4.
- R4: Requests to different banks are accepted in consecutive cycles with no gap, and at most one request is accepted per cycle.
- R5: When io_valid and cpu_valid are both 1, cpu_ready is 0 and the I/O request is served first.
- R6: While an I/O request waits on a busy bank, cpu_ready stays 0 even if the CPU's bank is idle, so the CPU never overtakes it.
- R7: A read accepted in cycle t gives rsp_valid = 1 in cycle t+2, with the stored word, its tag, and rsp_src (1 = I/O, 0 = CPU). Responses come out in acceptance order.
- R8: An accepted write produces no response, and a later read of the same address returns the written word.
- R9: All 72 bits of a word are stored and returned unchanged, including bits 71:64.
- R10: With eight_bank = 1, addresses that differ only in bit 3 fall in the same bank, so they conflict as in R3, and in different rows, so they keep separate data.
- R11: With eight_bank = 0, addresses that differ only in bit 3 fall in different banks and are accepted back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eight_bank | input | 1 | 1 selects half the bank count; held steady while banks are busy |
| io_valid | input | 1 | I/O request present |
| io_ready | output | 1 | I/O request taken this cycle when valid |
| io_addr | input | ADDR_W (10) | I/O word address |
| io_wdata | input | DATA_W (72) | I/O write word |
| io_we | input | 1 | I/O request is a write |
| io_tag | input | TAG_W (4) | I/O request tag |
| cpu_valid | input | 1 | CPU request present |
| cpu_ready | output | 1 | CPU request taken this cycle when valid |
| cpu_addr | input | ADDR_W (10) | CPU word address |
| cpu_wdata | input | DATA_W (72) | CPU write word |
| cpu_we | input | 1 | CPU request is a write |
| cpu_tag | input | TAG_W (4) | CPU request tag |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | DATA_W (72) | Read word |
| rsp_tag | output | TAG_W (4) | Tag of the read |
| rsp_src | output | 1 | 1 when the read came from the I/O port |

## Verification
The bench builds the block with its defaults: a 10-bit address, 16 banks at full count, a four-cycle bank recovery and a two-stage response path. These values let the bench probe every bank decode with short addresses. The recovery window is short enough that the exact wait of three cycles can be counted. Switching eight_bank at run time on the same build reaches both decodes, so one address pair can be shown to conflict in one mode and to stream in the other.

// File: rtl/msched_pkg.sv
// Shared types for the bank scheduler.
// Assumes nothing beyond a single clock domain.
package msched_pkg;

    // Which requester a request or response belongs to.
    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_IO  = 1'b1
    } src_e;

endpackage

// File: rtl/msched_arb.sv
// Fixed-priority arbiter for the shared port.
// The I/O requester always wins. The CPU is offered the port only while no
// I/O request is pending, even one stalled on a busy bank.
// Assumes the idle inputs already reflect each requester's own bank.
module msched_arb (
    input  logic io_valid,
    input  logic cpu_valid,
    input  logic io_bank_idle,
    input  logic cpu_bank_idle,
    output logic io_ready,
    output logic cpu_ready,
    output logic fire_io,
    output logic fire_cpu
);

    // Ready and grant decisions for both requesters.
    always_comb begin
        io_ready  = io_bank_idle;
        cpu_ready = !io_valid && cpu_bank_idle;
        fire_io   = io_valid && io_ready;
        fire_cpu  = cpu_valid && cpu_ready;
    end

endmodule

// File: rtl/msched_bank.sv
// One memory bank: its word store and its recovery counter.
// A select starts a bank cycle of BANK_CYCLE clocks. The bank reports idle
// only when the counter has run down. Reads register the addressed word.
// Assumes sel is asserted only while idle is high (the arbiter ensures it).
module msched_bank #(
    parameter int ROW_W      = 7,
    parameter int DATA_W     = 72,
    parameter int BANK_CYCLE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic              idle,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ROW_W;
    localparam int CNT_W = $clog2(BANK_CYCLE + 1);

    logic [CNT_W-1:0]  busy_cnt;
    logic [DATA_W-1:0] store [DEPTH];

    // Recovery counter: load on select, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (sel) begin
            busy_cnt <= CNT_W'(BANK_CYCLE - 1);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    // Word store write port.
    always_ff @(posedge clk) begin
        if (sel && we) begin
            store[row] <= wdata;
        end
    end

    // Registered read of the addressed word.
    always_ff @(posedge clk) begin
        if (sel && !we) begin
            rdata <= store[row];
        end
    end

    // Bank can take a new access once the counter is zero.
    always_comb begin
        idle = (busy_cnt == '0);
    end

endmodule

// File: rtl/msched_rsp.sv
// Read response path.
// The first stage records tag, source and bank as the banks capture data.
// The second stage picks the bank word. Further stages delay the result so
// that it appears RSP_LAT cycles after acceptance. Order is kept by construction.
// Assumes RSP_LAT >= 2.
module msched_rsp
    import msched_pkg::*;
#(
    parameter int NBANK     = 16,
    parameter int BANK_LOG2 = 4,
    parameter int DATA_W    = 72,
    parameter int TAG_W     = 4,
    parameter int RSP_LAT   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue,
    input  logic [TAG_W-1:0]             issue_tag,
    input  src_e                         issue_src,
    input  logic [BANK_LOG2-1:0]         issue_bank,
    input  logic [NBANK-1:0][DATA_W-1:0] bank_rdata,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_data,
    output logic [TAG_W-1:0]             out_tag,
    output logic                         out_src
);

    localparam int PIPE = RSP_LAT - 1;

    logic                 a_valid;
    logic [TAG_W-1:0]     a_tag;
    src_e                 a_src;
    logic [BANK_LOG2-1:0] a_bank;

    logic                 p_valid [PIPE];
    logic [DATA_W-1:0]    p_data  [PIPE];
    logic [TAG_W-1:0]     p_tag   [PIPE];
    src_e                 p_src   [PIPE];

    // Issue stage valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
        end else begin
            a_valid <= issue;
        end
    end

    // Issue stage side information.
    always_ff @(posedge clk) begin
        if (issue) begin
            a_tag  <= issue_tag;
            a_src  <= issue_src;
            a_bank <= issue_bank;
        end
    end

    // Delay pipe valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE; i++) begin
                p_valid[i] <= 1'b0;
            end
        end else begin
            p_valid[0] <= a_valid;
            for (int i = 1; i < PIPE; i++) begin
                p_valid[i] <= p_valid[i-1];
            end
        end
    end

    // Delay pipe payload; stage 0 selects the word of the recorded bank.
    always_ff @(posedge clk) begin
        p_data[0] <= bank_rdata[a_bank];
        p_tag[0]  <= a_tag;
        p_src[0]  <= a_src;
        for (int i = 1; i < PIPE; i++) begin
            p_data[i] <= p_data[i-1];
            p_tag[i]  <= p_tag[i-1];
            p_src[i]  <= p_src[i-1];
        end
    end

    // Output taken from the last stage.
    always_comb begin
        out_valid = p_valid[PIPE-1];
        out_data  = p_data[PIPE-1];
        out_tag   = p_tag[PIPE-1];
        out_src   = (p_src[PIPE-1] == SRC_IO);
    end

endmodule

// File: rtl/bank_sched.sv
// Interleaved memory bank scheduler, top level.
// Merges an I/O and a CPU request channel onto one port. I/O has fixed
// priority. Each request goes to the bank named by its low address bits.
// A request is held off while its bank is in its recovery cycle.
// Read words return RSP_LAT cycles after acceptance, in order.
// Assumes eight_bank changes only while all banks are idle, and BANK_LOG2 >= 2.
module bank_sched
    import msched_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 72,
    parameter int BANK_LOG2  = 4,
    parameter int BANK_CYCLE = 4,
    parameter int RSP_LAT    = 2,
    parameter int TAG_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eight_bank,
    input  logic              io_valid,
    output logic              io_ready,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_we,
    input  logic [TAG_W-1:0]  io_tag,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_src
);

    localparam int NBANK = 1 << BANK_LOG2;
    localparam int ROW_W = ADDR_W - BANK_LOG2 + 1;

    // Bank index from the low address bits for the current mode.
    function automatic logic [BANK_LOG2-1:0] bank_of(input logic [ADDR_W-1:0] a,
                                                     input logic half);
        bank_of = half ? {1'b0, a[BANK_LOG2-2:0]} : a[BANK_LOG2-1:0];
    endfunction

    // Row within the bank from the remaining address bits.
    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a,
                                                input logic half);
        row_of = half ? a[ADDR_W-1:BANK_LOG2-1] : {1'b0, a[ADDR_W-1:BANK_LOG2]};
    endfunction

    logic [BANK_LOG2-1:0]         io_bank, cpu_bank, sel_bank;
    logic [ROW_W-1:0]             sel_row;
    logic [DATA_W-1:0]            sel_wdata;
    logic [TAG_W-1:0]             sel_tag;
    logic                         sel_we;
    src_e                         sel_src;
    logic                         fire_io, fire_cpu, fire;
    logic [NBANK-1:0]             bank_idle;
    logic [NBANK-1:0]             bank_hit;
    logic [NBANK-1:0][DATA_W-1:0] bank_rd;

    // Bank lookup for both waiting requests.
    always_comb begin
        io_bank  = bank_of(io_addr, eight_bank);
        cpu_bank = bank_of(cpu_addr, eight_bank);
    end

    msched_arb u_arb (
        .io_valid      (io_valid),
        .cpu_valid     (cpu_valid),
        .io_bank_idle  (bank_idle[io_bank]),
        .cpu_bank_idle (bank_idle[cpu_bank]),
        .io_ready      (io_ready),
        .cpu_ready     (cpu_ready),
        .fire_io       (fire_io),
        .fire_cpu      (fire_cpu)
    );

    // Steer the granted request onto the shared port.
    always_comb begin
        fire = fire_io || fire_cpu;
        if (fire_io) begin
            sel_bank  = io_bank;
            sel_row   = row_of(io_addr, eight_bank);
            sel_wdata = io_wdata;
            sel_we    = io_we;
            sel_tag   = io_tag;
            sel_src   = SRC_IO;
        end else begin
            sel_bank  = cpu_bank;
            sel_row   = row_of(cpu_addr, eight_bank);
            sel_wdata = cpu_wdata;
            sel_we    = cpu_we;
            sel_tag   = cpu_tag;
            sel_src   = SRC_CPU;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Select line for this bank.
        always_comb begin
            bank_hit[b] = fire && (sel_bank == BANK_LOG2'(b));
        end

        msched_bank #(
            .ROW_W      (ROW_W),
            .DATA_W     (DATA_W),
            .BANK_CYCLE (BANK_CYCLE)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (bank_hit[b]),
            .we    (sel_we),
            .row   (sel_row),
            .wdata (sel_wdata),
            .idle  (bank_idle[b]),
            .rdata (bank_rd[b])
        );
    end

    msched_rsp #(
        .NBANK     (NBANK),
        .BANK_LOG2 (BANK_LOG2),
        .DATA_W    (DATA_W),
        .TAG_W     (TAG_W),
        .RSP_LAT   (RSP_LAT)
    ) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (fire && !sel_we),
        .issue_tag  (sel_tag),
        .issue_src  (sel_src),
        .issue_bank (sel_bank),
        .bank_rdata (bank_rd),
        .out_valid  (rsp_valid),
        .out_data   (rsp_data),
        .out_tag    (rsp_tag),
        .out_src    (rsp_src)
    );

endmodule

// File: rtl/bank_sched_chk.sv
// Protocol checker for bank_sched, attached by bind.
// Keeps its own per-bank age counters and its own response expectation pipe,
// fed only from the top-level ports.
module bank_sched_chk #(
    parameter int ADDR_W     = 10,
    parameter int BANK_LOG2  = 4,
    parameter int BANK_CYCLE = 4,
    parameter int RSP_LAT    = 2,
    parameter int TAG_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eight_bank,
    input logic              io_valid,
    input logic              io_ready,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_we,
    input logic [TAG_W-1:0]  io_tag,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_we,
    input logic [TAG_W-1:0]  cpu_tag,
    input logic              rsp_valid,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic              rsp_src
);

    localparam int NBANK = 1 << BANK_LOG2;
    localparam int AGE_W = $clog2(BANK_CYCLE + 1);

    logic                 io_fire, cpu_fire, any_fire, f_we;
    logic [ADDR_W-1:0]    f_addr;
    logic [TAG_W-1:0]     f_tag;
    logic [BANK_LOG2-1:0] f_bank;
    logic [AGE_W-1:0]     age [NBANK];
    logic                 exp_v [RSP_LAT];
    logic [TAG_W-1:0]     exp_t [RSP_LAT];
    logic                 exp_s [RSP_LAT];

    // Decode the accepted request from the ports.
    always_comb begin
        io_fire  = io_valid && io_ready;
        cpu_fire = cpu_valid && cpu_ready;
        any_fire = io_fire || cpu_fire;
        f_addr   = io_fire ? io_addr : cpu_addr;
        f_we     = io_fire ? io_we : cpu_we;
        f_tag    = io_fire ? io_tag : cpu_tag;
        f_bank   = eight_bank ? {1'b0, f_addr[BANK_LOG2-2:0]} : f_addr[BANK_LOG2-1:0];
    end

    // Cycles since each bank was last accessed, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBANK; i++) age[i] <= AGE_W'(BANK_CYCLE);
        end else begin
            for (int i = 0; i < NBANK; i++) begin
                if (any_fire && f_bank == BANK_LOG2'(i)) age[i] <= AGE_W'(1);
                else if (age[i] < AGE_W'(BANK_CYCLE)) age[i] <= age[i] + 1'b1;
            end
        end
    end

    // Expected response timing, tag and source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RSP_LAT; i++) begin
                exp_v[i] <= 1'b0;
                exp_t[i] <= '0;
                exp_s[i] <= 1'b0;
            end
        end else begin
            exp_v[0] <= any_fire && !f_we;
            exp_t[0] <= f_tag;
            exp_s[0] <= io_fire;
            for (int i = 1; i < RSP_LAT; i++) begin
                exp_v[i] <= exp_v[i-1];
                exp_t[i] <= exp_t[i-1];
                exp_s[i] <= exp_s[i-1];
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);

    assert_bank_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_fire |-> age[f_bank] >= AGE_W'(BANK_CYCLE));

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({io_fire, cpu_fire}) <= 1);

    assert_io_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && cpu_valid) |-> !cpu_ready);

    assert_no_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_ready) |-> !cpu_fire);

    assert_rsp_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == exp_v[RSP_LAT-1]);

    assert_rsp_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_tag == exp_t[RSP_LAT-1] && rsp_src == exp_s[RSP_LAT-1]));

endmodule

bind bank_sched bank_sched_chk #(
    .ADDR_W     (ADDR_W),
    .BANK_LOG2  (BANK_LOG2),
    .BANK_CYCLE (BANK_CYCLE),
    .RSP_LAT    (RSP_LAT),
    .TAG_W      (TAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eight_bank (eight_bank),
    .io_valid   (io_valid),
    .io_ready   (io_ready),
    .io_addr    (io_addr),
    .io_we      (io_we),
    .io_tag     (io_tag),
    .cpu_valid  (cpu_valid),
    .cpu_ready  (cpu_ready),
    .cpu_addr   (cpu_addr),
    .cpu_we     (cpu_we),
    .cpu_tag    (cpu_tag),
    .rsp_valid  (rsp_valid),
    .rsp_tag    (rsp_tag),
    .rsp_src    (rsp_src)
);

// File: tb/bank_sched_bench.sv
// Self-checking bench for bank_sched with default parameters.
module bank_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eight_bank = 1'b0;
    logic        io_valid = 1'b0, cpu_valid = 1'b0;
    logic        io_ready, cpu_ready;
    logic [9:0]  io_addr = '0, cpu_addr = '0;
    logic [71:0] io_wdata = '0, cpu_wdata = '0;
    logic        io_we = 1'b0, cpu_we = 1'b0;
    logic [3:0]  io_tag = '0, cpu_tag = '0;
    logic        rsp_valid;
    logic [71:0] rsp_data;
    logic [3:0]  rsp_tag;
    logic        rsp_src;

    int total = 0;
    int bad = 0;

    logic [71:0] model [1024];
    int          log_n = 0;
    logic [3:0]  log_tag [8];
    logic        log_src [8];

    always #4 clk = ~clk;

    bank_sched u_bank_sched (
        .clk(clk), .rst_n(rst_n), .eight_bank(eight_bank),
        .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_we(io_we), .io_tag(io_tag),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_tag(cpu_tag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
        .rsp_src(rsp_src)
    );

    // Stimulus table: we[23] io[22] addr[21:12] tag[11:8] seed[7:0]
    localparam logic [23:0] VEC [12] = '{
        {1'b1, 1'b0, 10'h000, 4'h1, 8'hA5},
        {1'b1, 1'b1, 10'h001, 4'h2, 8'h3C},
        {1'b1, 1'b0, 10'h3FF, 4'h3, 8'hFF},
        {1'b1, 1'b1, 10'h010, 4'h4, 8'h81},
        {1'b0, 1'b0, 10'h000, 4'h5, 8'h00},
        {1'b0, 1'b1, 10'h010, 4'h6, 8'h00},
        {1'b0, 1'b0, 10'h001, 4'h7, 8'h00},
        {1'b0, 1'b1, 10'h3FF, 4'h8, 8'h00},
        {1'b1, 1'b0, 10'h000, 4'h9, 8'h5A},
        {1'b0, 1'b0, 10'h000, 4'hA, 8'h00},
        {1'b0, 1'b1, 10'h010, 4'hB, 8'h00},
        {1'b0, 1'b0, 10'h001, 4'hC, 8'h00}
    };

    // Record every response seen, sampled mid-cycle.
    always @(negedge clk) begin
        if (rsp_valid && log_n < 8) begin
            log_tag[log_n] = rsp_tag;
            log_src[log_n] = rsp_src;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // One isolated request; for a read, d is the expected word.
    task automatic issue(input bit via_io, input bit we, input logic [9:0] a,
                         input logic [71:0] d, input logic [3:0] t);
        int guard;
        @(negedge clk);
        if (via_io) begin
            io_valid = 1'b1; io_we = we; io_addr = a; io_wdata = d; io_tag = t;
        end else begin
            cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_tag = t;
        end
        #1;
        guard = 0;
        while (!(via_io ? io_ready : cpu_ready) && guard < 20) begin
            @(negedge clk); #1; guard++;
        end
        @(posedge clk); #1;
        io_valid = 1'b0; cpu_valid = 1'b0;
        @(negedge clk); #1;
        chk(!rsp_valid, "R7", "no response one cycle after accept", 72'(rsp_valid), 72'd0);
        @(negedge clk); #1;
        if (we) begin
            chk(!rsp_valid, "R8", "write gives no response", 72'(rsp_valid), 72'd0);
        end else begin
            chk(rsp_valid, "R7", "response two cycles after accept", 72'(rsp_valid), 72'd1);
            chk(rsp_data == d, "R9", "read word", rsp_data, d);
            chk(rsp_tag == t, "R7", "response tag", 72'(rsp_tag), 72'(t));
            chk(rsp_src == via_io, "R7", "response source", 72'(rsp_src), 72'(via_io));
        end
        repeat (3) @(negedge clk);
    endtask

    // Two CPU reads, the second held until accepted; wc counts waiting cycles.
    task automatic pair(input logic [9:0] a1, input logic [9:0] a2,
                        input logic [3:0] t1, input logic [3:0] t2, output int wc);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a1; cpu_tag = t1;
        @(posedge clk);
        log_n = 0;
        #1;
        cpu_addr = a2; cpu_tag = t2;
        @(negedge clk); #1;
        wc = 0;
        while (!cpu_ready && wc < 20) begin
            @(negedge clk); #1; wc++;
        end
        @(posedge clk); #1;
        cpu_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(log_n == 2 && log_tag[0] == t1 && log_tag[1] == t2, "R7",
            "responses in order", 72'({log_tag[0], log_tag[1]}), 72'({t1, t2}));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL R1 watchdog expired act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wc;
        logic [23:0] v;
        logic [71:0] d;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R1", "rsp_valid in reset", 72'(rsp_valid), 72'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!rsp_valid, "R1", "rsp_valid after reset", 72'(rsp_valid), 72'd0);
        chk(io_ready && cpu_ready, "R1", "ready after reset",
            72'({io_ready, cpu_ready}), 72'd3);

        // Table walk: R2 bank decode, R7 latency, R8 writes, R9 full width.
        for (int i = 0; i < 12; i++) begin
            v = VEC[i];
            if (v[23]) begin
                d = {9{v[7:0]}};
                model[v[21:12]] = d;
            end else begin
                d = model[v[21:12]];
            end
            issue(v[22], v[23], v[21:12], d, v[11:8]);
        end

        // R3 and R2: same bank 0 via bits [3:0], three cycles of wait.
        pair(10'h030, 10'h040, 4'h1, 4'h2, wc);
        chk(wc == 3, "R3", "same-bank wait cycles", 72'(wc), 72'd3);
        // R4: neighbouring banks stream.
        pair(10'h030, 10'h031, 4'h3, 4'h4, wc);
        chk(wc == 0, "R4", "different-bank wait cycles", 72'(wc), 72'd0);
        // R11: bit 3 picks a different bank at full count.
        pair(10'h004, 10'h00C, 4'h5, 4'h6, wc);
        chk(wc == 0, "R11", "bit 3 separates banks", 72'(wc), 72'd0);

        // R5: both requesters at once.
        @(negedge clk);
        io_valid = 1'b1; io_we = 1'b0; io_addr = 10'h020; io_tag = 4'h5;
        cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h001; cpu_tag = 4'h6;
        #1;
        chk(io_ready && !cpu_ready, "R5", "I/O wins the port",
            72'({io_ready, cpu_ready}), 72'd2);
        @(posedge clk);
        log_n = 0;
        #1;
        io_valid = 1'b0;
        @(negedge clk); #1;
        chk(cpu_ready, "R5", "CPU served next cycle", 72'(cpu_ready), 72'd1);
        @(posedge clk); #1;
        cpu_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(log_n == 2 && log_src[0] && !log_src[1] && log_tag[0] == 4'h5 && log_tag[1] == 4'h6,
            "R5", "I/O response before CPU", 72'({log_src[0], log_src[1]}), 72'd2);
        repeat (3) @(negedge clk);

        // R6: stalled I/O blocks an idle-bank CPU request.
        @(negedge clk);
        io_valid = 1'b1; io_we = 1'b0; io_addr = 10'h002; io_tag = 4'h7;
        @(posedge clk);
        log_n = 0;
        #1;
        io_addr = 10'h012; io_tag = 4'h8;
        cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 10'h005; cpu_tag = 4'h9;
        @(negedge clk); #1;
        chk(!io_ready && !cpu_ready, "R6", "CPU held behind stalled I/O",
            72'({io_ready, cpu_ready}), 72'd0);
        wc = 0;
        while (!io_ready && wc < 20) begin
            if (cpu_ready) begin
                chk(1'b0, "R6", "CPU ready during I/O stall", 72'd1, 72'd0);
            end
            @(negedge clk); #1; wc++;
        end
        chk(wc == 3, "R6", "I/O stall length", 72'(wc), 72'd3);
        @(posedge clk); #1;
        io_valid = 1'b0;
        @(negedge clk); #1;
        chk(cpu_ready, "R6", "CPU follows I/O", 72'(cpu_ready), 72'd1);
        @(posedge clk); #1;
        cpu_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(log_n == 3 && log_tag[0] == 4'h7 && log_tag[1] == 4'h8 && log_tag[2] == 4'h9,
            "R6", "order after stall", 72'({log_tag[0], log_tag[1], log_tag[2]}), 72'h789);
        repeat (3) @(negedge clk);

        // R10: half count, bit 3 now lands in the same bank, separate rows.
        eight_bank = 1'b1;
        repeat (2) @(negedge clk);
        pair(10'h004, 10'h00C, 4'hA, 4'hB, wc);
        chk(wc == 3, "R10", "bit 3 conflicts at half count", 72'(wc), 72'd3);
        pair(10'h004, 10'h005, 4'hC, 4'hD, wc);
        chk(wc == 0, "R2", "bits [2:0] pick bank at half count", 72'(wc), 72'd0);
        issue(1'b0, 1'b1, 10'h004, {9{8'hC3}}, 4'h1);
        issue(1'b1, 1'b1, 10'h00C, {9{8'h96}}, 4'h2);
        issue(1'b0, 1'b0, 10'h004, {9{8'hC3}}, 4'h3);
        issue(1'b1, 1'b0, 10'h00C, {9{8'h96}}, 4'h4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule